// File: doc/BRIEF.md
# Per-Core Request Ordering Queue

This block sits at the network side of one shared-cache bank. Memory requests reach it tagged with the issuing core and a per-core sequence number that the core raises by one for every request it sends, so the pair is unique. The block parks each request in a small reorder store, addressed by core and by the low bits of the sequence number. It hands a parked request to the cache only when that request is the next one its core is owed across the whole system.

The "next owed" numbers travel on a token that circulates around a ring made of all banks' ordering stages. The token holds one expected sequence number per core. It moves one bank further each cycle. A bank that holds the token may release at most one request whose number matches the token's entry for its core, and passes the token on with that entry raised by one. One bank on the ring is built as the head and creates the token after reset. A lock mode narrows acceptance and release to a single named core, so that one core's critical-section stream drains on its own.

Top module: `bank_order_queue`

## Requirements
- R1: After reset no request is issued, and every core's expected sequence number is zero, so the first request released for any core carries sequence number 0.
- R2: For each core, requests leave the issue port in strictly increasing sequence order, one step at a time, across all banks of the ring. A request whose number differs from the token's entry for its core stays parked.
- R3: `req_ready` is low while the reorder slot addressed by (`req_core`, low log2(SLOTS) bits of `req_id`) is occupied, and high once that slot has been released.
- R4: A request is issued only in the cycle after the token was present at this bank, and at most one per visit. The token is forwarded one cycle after it arrives, with the issued core's entry raised by one and all other entries unchanged.
- R5: The bank built as ring head emits a token with all entries zero in the first cycle after reset. A bank not built as head emits nothing until a token reaches it.
- R6: The payload, core and sequence number of an issued request equal the values it was accepted with.
- R7: While `lock_en` is high, requests from any core other than `lock_core` see `req_ready` low and are neither accepted nor issued.
- R8: Sequence numbers wrap modulo 2^ID_W. The entry after the largest value is 0, and ordering continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_core | input | CW | Issuing core index |
| req_id | input | ID_W | Per-core sequence number |
| req_data | input | DATA_W | Request payload |
| lock_en | input | 1 | Lock mode active |
| lock_core | input | CW | Core allowed while locked |
| tok_in_vld | input | 1 | Token arriving from previous bank |
| tok_in_exp | input | NUM_CORES*ID_W | Expected number per core, core c at bits c*ID_W upward |
| tok_out_vld | output | 1 | Token leaving to next bank |
| tok_out_exp | output | NUM_CORES*ID_W | Updated expected numbers |
| iss_vld | output | 1 | Request issued to the cache |
| iss_core | output | CW | Core of issued request |
| iss_id | output | ID_W | Sequence number of issued request |
| iss_data | output | DATA_W | Payload of issued request |

## Verification
The bench builds a two-bank ring with four cores, 4-bit sequence numbers and four slots per core, so the token returns to a bank every second cycle. With only four slots per core, a number and the same number plus four collide on one slot, which makes the backpressure case reachable. With 4-bit numbers, a few dozen requests per core carry the sequence through several wraps. Requests are deliberately sent to the wrong bank first and in reversed or shuffled order with random gaps. A merged monitor over both issue ports then proves the per-core release order, payload integrity and token increment.

// File: rtl/order_pkg.sv
package order_pkg;
   // Width of an index over n items, never less than one bit.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/order_reorder_array.sv
module order_reorder_array #(
   parameter int NUM_CORES = 4,
   parameter int ID_W      = 4,
   parameter int DATA_W    = 16,
   parameter int SLOTS     = 4,
   localparam int CW       = order_pkg::idx_w(NUM_CORES),
   localparam int SW       = order_pkg::idx_w(SLOTS),
   localparam int ENT      = NUM_CORES * SLOTS,
   localparam int AW       = order_pkg::idx_w(ENT)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr_en,
   input  logic [CW-1:0]             wr_core,
   input  logic [ID_W-1:0]           wr_id,
   input  logic [DATA_W-1:0]         wr_data,
   output logic                      wr_busy,
   input  logic                      clr_en,
   input  logic [CW-1:0]             clr_core,
   input  logic [NUM_CORES*ID_W-1:0] exp_flat,
   output logic [NUM_CORES-1:0]      head_hit,
   output logic [NUM_CORES*DATA_W-1:0] head_data
);
   logic [ENT-1:0]    vld_q;
   logic [ID_W-1:0]   id_q  [ENT];
   logic [DATA_W-1:0] dat_q [ENT];

   logic [AW-1:0] wr_idx;
   logic [AW-1:0] clr_idx;
   logic [AW-1:0] head_idx [NUM_CORES];

   always_comb begin
      wr_idx = AW'(int'(wr_core) * SLOTS + int'(wr_id[SW-1:0]));
      if (int'(wr_core) >= NUM_CORES) wr_busy = 1'b1;
      else                            wr_busy = vld_q[wr_idx];
   end

   // Lookup of the slot each core's expected number maps to.
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_head
      logic [ID_W-1:0] exp_c;
      assign exp_c       = exp_flat[c*ID_W +: ID_W];
      assign head_idx[c] = AW'(c * SLOTS + int'(exp_c[SW-1:0]));
      assign head_hit[c] = vld_q[head_idx[c]] && (id_q[head_idx[c]] == exp_c);
      assign head_data[c*DATA_W +: DATA_W] = dat_q[head_idx[c]];
   end

   always_comb begin
      clr_idx = head_idx[0];
      for (int c = 0; c < NUM_CORES; c++)
         if (clr_core == CW'(c)) clr_idx = head_idx[c];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else begin
         if (clr_en) vld_q[clr_idx] <= 1'b0;
         if (wr_en)  vld_q[wr_idx]  <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         id_q[wr_idx]  <= wr_id;
         dat_q[wr_idx] <= wr_data;
      end
   end
endmodule

// File: rtl/order_issue_select.sv
module order_issue_select #(
   parameter int NUM_CORES = 4,
   localparam int CW       = order_pkg::idx_w(NUM_CORES)
) (
   input  logic [NUM_CORES-1:0] head_hit,
   input  logic                 lock_en,
   input  logic [CW-1:0]        lock_core,
   output logic                 pick_vld,
   output logic [CW-1:0]        pick_core
);
   logic [NUM_CORES-1:0] allow;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_allow
      assign allow[c] = !lock_en || (lock_core == CW'(c));
   end

   // Fixed priority: the lowest core index that can go wins.
   always_comb begin
      pick_vld  = 1'b0;
      pick_core = '0;
      for (int c = NUM_CORES - 1; c >= 0; c--) begin
         if (head_hit[c] && allow[c]) begin
            pick_vld  = 1'b1;
            pick_core = CW'(c);
         end
      end
   end
endmodule

// File: rtl/order_token_stage.sv
module order_token_stage #(
   parameter int NUM_CORES = 4,
   parameter int ID_W      = 4,
   parameter int DATA_W    = 16,
   parameter bit IS_HEAD   = 1'b0,
   localparam int CW       = order_pkg::idx_w(NUM_CORES),
   localparam int TW       = NUM_CORES * ID_W
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        tok_in_vld,
   input  logic [TW-1:0]               tok_in_exp,
   input  logic                        pick_vld,
   input  logic [CW-1:0]               pick_core,
   input  logic [NUM_CORES*DATA_W-1:0] head_data,
   output logic                        fire,
   output logic                        tok_out_vld,
   output logic [TW-1:0]               tok_out_exp,
   output logic                        iss_vld,
   output logic [CW-1:0]               iss_core,
   output logic [ID_W-1:0]             iss_id,
   output logic [DATA_W-1:0]           iss_data
);
   logic [TW-1:0]     next_exp;
   logic [ID_W-1:0]   pick_id;
   logic [DATA_W-1:0] pick_data;
   logic              inject;

   assign fire = tok_in_vld && pick_vld;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_bump
      logic [ID_W-1:0] cur;
      assign cur = tok_in_exp[c*ID_W +: ID_W];
      assign next_exp[c*ID_W +: ID_W] =
         (fire && pick_core == CW'(c)) ? cur + ID_W'(1) : cur;
   end

   always_comb begin
      pick_id   = '0;
      pick_data = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (pick_core == CW'(c)) begin
            pick_id   = tok_in_exp[c*ID_W +: ID_W];
            pick_data = head_data[c*DATA_W +: DATA_W];
         end
      end
   end

   // Ring head creates the token once after reset; others never do.
   if (IS_HEAD) begin : g_head
      logic injected_q;
      always_ff @(posedge clk) begin
         if (rst) injected_q <= 1'b0;
         else     injected_q <= 1'b1;
      end
      assign inject = !injected_q && !tok_in_vld;
   end else begin : g_member
      assign inject = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tok_out_vld <= 1'b0;
         tok_out_exp <= '0;
         iss_vld     <= 1'b0;
         iss_core    <= '0;
         iss_id      <= '0;
         iss_data    <= '0;
      end else begin
         tok_out_vld <= tok_in_vld || inject;
         tok_out_exp <= tok_in_vld ? next_exp : '0;
         iss_vld     <= fire;
         if (fire) begin
            iss_core <= pick_core;
            iss_id   <= pick_id;
            iss_data <= pick_data;
         end
      end
   end
endmodule

// File: rtl/bank_order_queue.sv
module bank_order_queue #(
   parameter int NUM_CORES = 4,
   parameter int ID_W      = 4,
   parameter int DATA_W    = 16,
   parameter int SLOTS     = 4,
   parameter bit IS_HEAD   = 1'b0,
   localparam int CW       = order_pkg::idx_w(NUM_CORES),
   localparam int TW       = NUM_CORES * ID_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_vld,
   output logic              req_ready,
   input  logic [CW-1:0]     req_core,
   input  logic [ID_W-1:0]   req_id,
   input  logic [DATA_W-1:0] req_data,
   input  logic              lock_en,
   input  logic [CW-1:0]     lock_core,
   input  logic              tok_in_vld,
   input  logic [TW-1:0]     tok_in_exp,
   output logic              tok_out_vld,
   output logic [TW-1:0]     tok_out_exp,
   output logic              iss_vld,
   output logic [CW-1:0]     iss_core,
   output logic [ID_W-1:0]   iss_id,
   output logic [DATA_W-1:0] iss_data
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (SLOTS > (1 << ID_W)) begin : g_bad_window
      $error("SLOTS may not exceed the sequence number space");
   end
   if (NUM_CORES < 1 || DATA_W < 1) begin : g_bad_sizes
      $error("NUM_CORES and DATA_W must be positive");
   end

   logic                        wr_busy;
   logic                        accept;
   logic                        lock_ok;
   logic [NUM_CORES-1:0]        head_hit;
   logic [NUM_CORES*DATA_W-1:0] head_data;
   logic                        pick_vld;
   logic [CW-1:0]               pick_core;
   logic                        fire;

   assign lock_ok   = !lock_en || (req_core == lock_core);
   assign req_ready = !wr_busy && lock_ok;
   assign accept    = req_vld && req_ready;

   order_reorder_array #(
      .NUM_CORES(NUM_CORES), .ID_W(ID_W), .DATA_W(DATA_W), .SLOTS(SLOTS)
   ) u_array (
      .clk(clk), .rst(rst),
      .wr_en(accept), .wr_core(req_core), .wr_id(req_id), .wr_data(req_data),
      .wr_busy(wr_busy),
      .clr_en(fire), .clr_core(pick_core),
      .exp_flat(tok_in_exp), .head_hit(head_hit), .head_data(head_data)
   );

   order_issue_select #(.NUM_CORES(NUM_CORES)) u_select (
      .head_hit(head_hit), .lock_en(lock_en), .lock_core(lock_core),
      .pick_vld(pick_vld), .pick_core(pick_core)
   );

   order_token_stage #(
      .NUM_CORES(NUM_CORES), .ID_W(ID_W), .DATA_W(DATA_W), .IS_HEAD(IS_HEAD)
   ) u_token (
      .clk(clk), .rst(rst),
      .tok_in_vld(tok_in_vld), .tok_in_exp(tok_in_exp),
      .pick_vld(pick_vld), .pick_core(pick_core), .head_data(head_data),
      .fire(fire),
      .tok_out_vld(tok_out_vld), .tok_out_exp(tok_out_exp),
      .iss_vld(iss_vld), .iss_core(iss_core), .iss_id(iss_id), .iss_data(iss_data)
   );
endmodule

// File: rtl/order_checker.sv
module order_checker #(
   parameter int NUM_CORES = 4,
   parameter int ID_W      = 4,
   parameter int DATA_W    = 16,
   localparam int CW       = order_pkg::idx_w(NUM_CORES),
   localparam int TW       = NUM_CORES * ID_W
) (
   input logic              clk,
   input logic              rst,
   input logic              req_vld,
   input logic              req_ready,
   input logic [CW-1:0]     req_core,
   input logic              lock_en,
   input logic [CW-1:0]     lock_core,
   input logic              tok_in_vld,
   input logic [TW-1:0]     tok_in_exp,
   input logic              tok_out_vld,
   input logic [TW-1:0]     tok_out_exp,
   input logic              iss_vld,
   input logic [CW-1:0]     iss_core,
   input logic [ID_W-1:0]   iss_id
);
   // R4: an issue needs the token in the previous cycle
   p_issue_needs_token_r4: assert property (@(posedge clk) disable iff (rst)
      iss_vld |-> $past(tok_in_vld));

   // R4: the token is never dropped on its way round
   p_token_forwarded_r4: assert property (@(posedge clk) disable iff (rst)
      tok_in_vld |=> tok_out_vld);

   // R4 R8: forwarded entry of the issued core is one above the issued number
   p_token_bump_r4: assert property (@(posedge clk) disable iff (rst)
      iss_vld |-> (ID_W'(tok_out_exp >> (int'(iss_core) * ID_W)) == iss_id + ID_W'(1)));

   // R2: the issued number is the one the token asked for
   p_issue_in_order_r2: assert property (@(posedge clk) disable iff (rst)
      iss_vld |-> (iss_id == ID_W'($past(tok_in_exp) >> (int'(iss_core) * ID_W))));

   // R7: other cores are refused while locked
   p_lock_refuse_r7: assert property (@(posedge clk) disable iff (rst)
      (lock_en && req_vld && req_core != lock_core) |-> !req_ready);

   // R7: only the locked core is released while locked
   p_lock_issue_r7: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && $past(lock_en)) |-> (iss_core == $past(lock_core)));
endmodule

bind bank_order_queue order_checker #(
   .NUM_CORES(NUM_CORES), .ID_W(ID_W), .DATA_W(DATA_W)
) u_order_checker (
   .clk(clk), .rst(rst), .req_vld(req_vld), .req_ready(req_ready),
   .req_core(req_core), .lock_en(lock_en), .lock_core(lock_core),
   .tok_in_vld(tok_in_vld), .tok_in_exp(tok_in_exp),
   .tok_out_vld(tok_out_vld), .tok_out_exp(tok_out_exp),
   .iss_vld(iss_vld), .iss_core(iss_core), .iss_id(iss_id)
);

// File: tb/test_bank_order_queue.sv
module test_bank_order_queue;
   localparam int NC = 4;
   localparam int IW = 4;
   localparam int DW = 16;
   localparam int SL = 4;
   localparam int CW = 2;
   localparam int TW = NC * IW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic          rv [2];
   logic          rr [2];
   logic [CW-1:0] rc [2];
   logic [IW-1:0] ri [2];
   logic [DW-1:0] rd [2];
   logic          lk_en;
   logic [CW-1:0] lk_core;
   logic          tv [2];
   logic [TW-1:0] te [2];
   logic          iv [2];
   logic [CW-1:0] ic [2];
   logic [IW-1:0] ii [2];
   logic [DW-1:0] idat [2];

   bank_order_queue #(.NUM_CORES(NC), .ID_W(IW), .DATA_W(DW), .SLOTS(SL), .IS_HEAD(1'b1))
   i_bank_order_queue (
      .clk(clk), .rst(rst), .req_vld(rv[0]), .req_ready(rr[0]), .req_core(rc[0]),
      .req_id(ri[0]), .req_data(rd[0]), .lock_en(lk_en), .lock_core(lk_core),
      .tok_in_vld(tv[1]), .tok_in_exp(te[1]), .tok_out_vld(tv[0]), .tok_out_exp(te[0]),
      .iss_vld(iv[0]), .iss_core(ic[0]), .iss_id(ii[0]), .iss_data(idat[0]));

   bank_order_queue #(.NUM_CORES(NC), .ID_W(IW), .DATA_W(DW), .SLOTS(SL), .IS_HEAD(1'b0))
   i_bank_order_queue_peer (
      .clk(clk), .rst(rst), .req_vld(rv[1]), .req_ready(rr[1]), .req_core(rc[1]),
      .req_id(ri[1]), .req_data(rd[1]), .lock_en(lk_en), .lock_core(lk_core),
      .tok_in_vld(tv[0]), .tok_in_exp(te[0]), .tok_out_vld(tv[1]), .tok_out_exp(te[1]),
      .iss_vld(iv[1]), .iss_core(ic[1]), .iss_id(ii[1]), .iss_data(idat[1]));

   int checks = 0;
   int errors = 0;
   int issued [NC];
   int sent [NC];
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Merged monitor over both issue ports (R2, R4, R6, R8)
   always @(negedge clk) begin
      if (!rst) begin
         check(!(iv[0] && iv[1]), "R4", "two banks issued in one cycle", 1, 0);
         for (int b = 0; b < 2; b++) begin
            if (iv[b]) begin
               int c;
               c = int'(ic[b]);
               check(int'(ii[b]) == issued[c] % 16, "R2", "issued sequence number",
                     int'(ii[b]), issued[c] % 16);
               check(int'(idat[b]) == c * 4096 + issued[c], "R6", "issued payload",
                     int'(idat[b]), c * 4096 + issued[c]);
               check(tv[b] && int'(te[b][c*IW +: IW]) == (issued[c] + 1) % 16,
                     "R4", "forwarded token entry", int'(te[b][c*IW +: IW]),
                     (issued[c] + 1) % 16);
               issued[c]++;
            end
         end
      end
   end

   task automatic present(input int b, input int c, input int seq);
      rc[b] = CW'(c);
      ri[b] = IW'(seq % 16);
      rd[b] = DW'(c * 4096 + seq);
   endtask

   task automatic send(input int b, input int c, input int seq);
      @(negedge clk);
      present(b, c, seq);
      rv[b] = 1'b1;
      #1;
      while (!rr[b]) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      rv[b] = 1'b0;
      sent[c]++;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_issued(input int c, input int n, input string req);
      int t;
      t = 0;
      while (issued[c] < n && t < 400) begin
         @(negedge clk);
         t++;
      end
      wait_cycles(2);
      check(issued[c] == n, req, $sformatf("issue count core %0d", c), issued[c], n);
   endtask

   task automatic t_reset();
      // first negedge after reset release: head has emitted the zero token
      @(negedge clk);
      check(tv[0] == 1'b1, "R5", "head token valid", int'(tv[0]), 1);
      check(te[0] == '0, "R1", "head token entries", int'(te[0]), 0);
      check(tv[1] == 1'b0, "R5", "member token idle", int'(tv[1]), 0);
      check(iv[0] == 1'b0 && iv[1] == 1'b0, "R1", "no issue after reset",
            int'(iv[0]) + int'(iv[1]), 0);
      present(1, 0, 0);
      #1;
      check(rr[1] == 1'b1, "R1", "ready after reset", int'(rr[1]), 1);
   endtask

   task automatic t_order();
      send(0, 0, 1);           // number 1 arrives before number 0
      wait_cycles(8);
      check(issued[0] == 0, "R2", "higher number held back", issued[0], 0);
      send(1, 0, 0);
      wait_issued(0, 2, "R2");
   endtask

   task automatic t_backpressure();
      send(0, 2, 1);
      @(negedge clk);
      present(0, 2, 5);        // same slot as number 1
      #1;
      check(rr[0] == 1'b0, "R3", "slot occupied gives backpressure", int'(rr[0]), 0);
      present(0, 2, 2);
      #1;
      check(rr[0] == 1'b1, "R3", "free slot accepted", int'(rr[0]), 1);
      send(1, 2, 0);
      wait_issued(2, 2, "R3");
      present(0, 2, 5);
      #1;
      check(rr[0] == 1'b1, "R3", "slot free after release", int'(rr[0]), 1);
      send(1, 2, 3);
      send(0, 2, 4);
      send(0, 2, 5);
      send(1, 2, 2);
      wait_issued(2, 6, "R2");
   endtask

   task automatic t_lock();
      @(negedge clk);
      lk_en = 1'b1;
      lk_core = 2'd3;
      present(0, 1, 0);
      #1;
      check(rr[0] == 1'b0, "R7", "other core refused while locked", int'(rr[0]), 0);
      present(1, 3, 0);
      #1;
      check(rr[1] == 1'b1, "R7", "locked core accepted", int'(rr[1]), 1);
      send(0, 3, 1);
      send(1, 3, 0);
      wait_issued(3, 2, "R7");
      check(issued[1] == 0, "R7", "other core not issued while locked", issued[1], 0);
      @(negedge clk);
      lk_en = 1'b0;
      send(0, 1, 0);
      wait_issued(1, 1, "R7");
   endtask

   task automatic t_shuffle();
      for (int round = 0; round < 7; round++) begin
         for (int c = 0; c < NC; c++) begin
            int base;
            bit rev;
            base = sent[c];
            rev = 1'($urandom);
            for (int k = 0; k < 4; k++) begin
               int seq;
               seq = rev ? base + 3 - k : base + k;
               wait_cycles(int'($urandom % 4));
               send(int'($urandom % 2), c, seq);
            end
         end
         for (int c = 0; c < NC; c++) wait_issued(c, sent[c], "R8");
      end
      check(issued[0] > 16, "R8", "sequence wrapped", issued[0], 17);
   endtask

   initial begin
      for (int b = 0; b < 2; b++) begin
         rv[b] = 1'b0; rc[b] = '0; ri[b] = '0; rd[b] = '0;
      end
      lk_en = 1'b0;
      lk_core = '0;
      for (int c = 0; c < NC; c++) begin
         issued[c] = 0;
         sent[c] = 0;
      end
      wait_cycles(3);
      rst = 1'b0;
      t_reset();
      t_order();
      t_backpressure();
      t_lock();
      t_shuffle();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", "run did not finish", 0, 1);
         summary();
      end
   end
endmodule